// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This block turns one multi-register memory transfer request into a series of single-word accesses. A request carries a base address, a 16-bit mask of selected registers, a walk mode, a load/store direction and a flag that asks for the base to be updated. The sequencer then presents one access per selected register. Each access carries the register index and the word address. The memory side accepts an access with a valid/ready handshake.

The mode field takes two forms. In the first form it names one of four walks: increment-after, increment-before, decrement-after and decrement-before. In the second form it names a stack discipline: full or empty, ascending or descending. That discipline is mapped onto a walk, and the mapping depends on whether the request is a load or a store. In every walk the lowest-numbered selected register goes to the lowest address. When the last access has been accepted, the block raises a one-cycle completion pulse. With that pulse it presents the updated base and a write strobe for it. A separate flag marks a load whose mask includes the top register, so that the surrounding core can treat it as a return from a handler.

Top module: `bts_sequencer`

## Requirements
- R1: While reset is held and after it is released, busy_o, xfer_valid_o, done_o, wb_we_o and ret_load_o are all 0.
- R2: Exactly one access is issued for each set bit of the register mask. The register indices come out in strictly ascending order.
- R3: In increment-after mode (mode_i = 3'b000) the first address is the base. In increment-before mode (3'b001) the first address is base + 4.
- R4: In decrement-before mode (3'b011) the first address is base - 4*n, where n is the number of set bits. In decrement-after mode (3'b010) the first address is base - 4*n + 4. In every mode each accepted access moves the address up by 4, with 32-bit wraparound.
- R5: On the completion pulse, wb_base_o equals base + 4*n for increment modes and base - 4*n for decrement modes. wb_we_o is high on that cycle only when wb_en_i was set with the request.
- R6: For stores, the stack forms (mode_i[2] = 1, mode_i[1:0] = 0 full-descending, 1 empty-descending, 2 full-ascending, 3 empty-ascending) map in that order to decrement-before, decrement-after, increment-before and increment-after.
- R7: For loads, the same stack forms map in that order to increment-after, increment-before, decrement-after and decrement-before.
- R8: An access advances only on a cycle with xfer_valid_o and xfer_ready_i both high. While ready is low, the index, the address and the last flag hold steady. xfer_last_o marks the final access.
- R9: A request with an empty mask issues no access. Its completion pulse comes on the cycle after the start, with wb_base_o equal to the base.
- R10: ret_load_o pulses with the completion pulse exactly when the request was a load and bit 15 of the mask was set.
- R11: A start pulse that arrives while busy_o is high is ignored, and the operation in progress completes unchanged.
- R12: The first access is valid on the cycle after the start. The completion pulse comes on the cycle after the last access is accepted and lasts one cycle. The block is idle on the cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request strobe, taken only when idle |
| base_i | input | 32 | Base address |
| reg_list_i | input | 16 | Selected register mask |
| mode_i | input | 3 | Bit 2 selects stack form; bits 1:0 select walk or stack type |
| load_i | input | 1 | 1 = load, 0 = store |
| wb_en_i | input | 1 | Request base update |
| busy_o | output | 1 | Operation in progress |
| xfer_valid_o | output | 1 | Access presented |
| xfer_ready_i | input | 1 | Memory side accepts access |
| xfer_reg_o | output | 4 | Register index of access |
| xfer_addr_o | output | 32 | Word address of access |
| xfer_load_o | output | 1 | Direction of access |
| xfer_last_o | output | 1 | Final access of the operation |
| done_o | output | 1 | One-cycle completion pulse |
| wb_we_o | output | 1 | Base write strobe |
| wb_base_o | output | 32 | Updated base value |
| ret_load_o | output | 1 | Load including the top register completed |

## Verification
The first access is due one cycle after the start is sampled. Each later access is due one cycle after the previous one is accepted. The completion pulse, together with the write-back value and the strobes, is due one cycle after the last acceptance, or one cycle after the start for an empty mask. Idle follows one cycle later. The bench drives inputs and samples outputs at the falling edge, so every rising edge in between is exactly one register stage. It keeps its own count of accepted accesses, and uses that count to predict the index and address due at each sample. A ready pattern with stalls shows that nothing moves without acceptance.

// File: rtl/bts_pkg.sv
package bts_pkg;

  typedef enum logic [1:0] {
    WALK_INC_AFTER  = 2'd0,
    WALK_INC_BEFORE = 2'd1,
    WALK_DEC_AFTER  = 2'd2,
    WALK_DEC_BEFORE = 2'd3
  } walk_mode_e;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_RUN  = 2'd1,
    SEQ_FIN  = 2'd2
  } seq_state_e;

  localparam logic [1:0] STK_FULL_DESC  = 2'd0;
  localparam logic [1:0] STK_EMPTY_DESC = 2'd1;
  localparam logic [1:0] STK_FULL_ASC   = 2'd2;
  localparam logic [1:0] STK_EMPTY_ASC  = 2'd3;

  // Stack discipline to walk: a store pushes, a load pops the opposite way.
  function automatic walk_mode_e stack_to_walk(input logic [1:0] stk, input logic is_load);
    walk_mode_e w;
    case (stk)
      STK_FULL_DESC:  w = is_load ? WALK_INC_AFTER  : WALK_DEC_BEFORE;
      STK_EMPTY_DESC: w = is_load ? WALK_INC_BEFORE : WALK_DEC_AFTER;
      STK_FULL_ASC:   w = is_load ? WALK_DEC_AFTER  : WALK_INC_BEFORE;
      default:        w = is_load ? WALK_DEC_BEFORE : WALK_INC_AFTER;
    endcase
    return w;
  endfunction

  function automatic logic walk_is_dec(input walk_mode_e w);
    return (w == WALK_DEC_AFTER) || (w == WALK_DEC_BEFORE);
  endfunction

endpackage

// File: rtl/bts_mode_decode.sv
module bts_mode_decode
  import bts_pkg::*;
(
  input  logic [2:0] mode_i,
  input  logic       load_i,
  output walk_mode_e walk_o
);
  always_comb begin
    if (mode_i[2]) walk_o = stack_to_walk(mode_i[1:0], load_i);
    else           walk_o = walk_mode_e'(mode_i[1:0]);
  end
endmodule

// File: rtl/bts_addr_calc.sv
module bts_addr_calc
  import bts_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int NREG       = 16,
  parameter int WORD_BYTES = 4
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [NREG-1:0]   list_i,
  input  walk_mode_e        walk_i,
  output logic [ADDR_W-1:0] first_o,
  output logic [ADDR_W-1:0] final_o
);
  localparam int CNT_W = $clog2(NREG + 1);

  function automatic logic [CNT_W-1:0] count_set(input logic [NREG-1:0] m);
    logic [CNT_W-1:0] c;
    c = '0;
    for (int i = 0; i < NREG; i++) c = c + CNT_W'(m[i]);
    return c;
  endfunction

  function automatic logic [ADDR_W-1:0] span_bytes(input logic [CNT_W-1:0] c);
    return ADDR_W'(c) * ADDR_W'(WORD_BYTES);
  endfunction

  logic [ADDR_W-1:0] span;
  logic [ADDR_W-1:0] low_addr;
  logic              dec;

  always_comb begin
    span     = span_bytes(count_set(list_i));
    dec      = walk_is_dec(walk_i);
    low_addr = base_i - span;
    case (walk_i)
      WALK_INC_AFTER:  first_o = base_i;
      WALK_INC_BEFORE: first_o = base_i + ADDR_W'(WORD_BYTES);
      WALK_DEC_AFTER:  first_o = low_addr + ADDR_W'(WORD_BYTES);
      default:         first_o = low_addr;
    endcase
    final_o = dec ? low_addr : (base_i + span);
  end
endmodule

// File: rtl/bts_low_pick.sv
module bts_low_pick #(
  parameter int NREG  = 16,
  parameter int IDX_W = $clog2(NREG)
) (
  input  logic [NREG-1:0]  mask_i,
  output logic [NREG-1:0]  onehot_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             single_o
);
  logic [NREG:0] seen;
  assign seen[0] = 1'b0;

  for (genvar i = 0; i < NREG; i++) begin : g_chain
    assign onehot_o[i] = mask_i[i] & ~seen[i];
    assign seen[i+1]   = seen[i] | mask_i[i];
  end

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < NREG; i++)
      if (onehot_o[i]) idx_o = idx_o | IDX_W'(i);
  end

  assign single_o = (mask_i != '0) && ((mask_i & ~onehot_o) == '0);
endmodule

// File: rtl/bts_sequencer.sv
module bts_sequencer
  import bts_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int NREG       = 16,
  parameter int WORD_BYTES = 4,
  localparam int IDX_W     = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [NREG-1:0]   reg_list_i,
  input  logic [2:0]        mode_i,
  input  logic              load_i,
  input  logic              wb_en_i,
  output logic              busy_o,
  output logic              xfer_valid_o,
  input  logic              xfer_ready_i,
  output logic [IDX_W-1:0]  xfer_reg_o,
  output logic [ADDR_W-1:0] xfer_addr_o,
  output logic              xfer_load_o,
  output logic              xfer_last_o,
  output logic              done_o,
  output logic              wb_we_o,
  output logic [ADDR_W-1:0] wb_base_o,
  output logic              ret_load_o
);
  seq_state_e        state_q;
  logic [NREG-1:0]   mask_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] final_q;
  logic              load_q, wb_q, top_q;

  walk_mode_e        walk;
  logic [ADDR_W-1:0] first_addr, final_addr;
  logic [NREG-1:0]   pick_onehot;
  logic [IDX_W-1:0]  pick_idx;
  logic              pick_single;

  // Named events for the checks below.
  logic start_take, xfer_fire, last_fire;

  bts_mode_decode u_dec (
    .mode_i (mode_i),
    .load_i (load_i),
    .walk_o (walk)
  );

  bts_addr_calc #(.ADDR_W(ADDR_W), .NREG(NREG), .WORD_BYTES(WORD_BYTES)) u_calc (
    .base_i  (base_i),
    .list_i  (reg_list_i),
    .walk_i  (walk),
    .first_o (first_addr),
    .final_o (final_addr)
  );

  bts_low_pick #(.NREG(NREG), .IDX_W(IDX_W)) u_pick (
    .mask_i   (mask_q),
    .onehot_o (pick_onehot),
    .idx_o    (pick_idx),
    .single_o (pick_single)
  );

  assign start_take = start_i && (state_q == SEQ_IDLE);
  assign xfer_fire  = (state_q == SEQ_RUN) && xfer_ready_i;
  assign last_fire  = xfer_fire && pick_single;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      mask_q  <= '0;
      addr_q  <= '0;
      final_q <= '0;
      load_q  <= 1'b0;
      wb_q    <= 1'b0;
      top_q   <= 1'b0;
    end else begin
      case (state_q)
        SEQ_IDLE: if (start_take) begin
          mask_q  <= reg_list_i;
          addr_q  <= first_addr;
          final_q <= final_addr;
          load_q  <= load_i;
          wb_q    <= wb_en_i;
          top_q   <= reg_list_i[NREG-1];
          state_q <= (reg_list_i == '0) ? SEQ_FIN : SEQ_RUN;
        end
        SEQ_RUN: if (xfer_fire) begin
          mask_q <= mask_q & ~pick_onehot;
          addr_q <= addr_q + ADDR_W'(WORD_BYTES);
          if (pick_single) state_q <= SEQ_FIN;
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign busy_o       = (state_q != SEQ_IDLE);
  assign xfer_valid_o = (state_q == SEQ_RUN);
  assign xfer_reg_o   = pick_idx;
  assign xfer_addr_o  = addr_q;
  assign xfer_load_o  = load_q;
  assign xfer_last_o  = xfer_valid_o && pick_single;
  assign done_o       = (state_q == SEQ_FIN);
  assign wb_we_o      = done_o && wb_q;
  assign wb_base_o    = final_q;
  assign ret_load_o   = done_o && load_q && top_q;

  assert_hold_on_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid_o && !xfer_ready_i) |=> (xfer_valid_o && $stable(xfer_reg_o)
      && $stable(xfer_addr_o) && $stable(xfer_last_o)));

  assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_fire && !pick_single) |=> (xfer_addr_o == $past(xfer_addr_o) + ADDR_W'(WORD_BYTES)));

  assert_reg_ascend_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_fire && !pick_single) |=> (xfer_valid_o && (xfer_reg_o > $past(xfer_reg_o))));

  assert_done_after_last_R12: assert property (@(posedge clk) disable iff (!rst_n)
    last_fire |=> (done_o && !xfer_valid_o));

  assert_done_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && !busy_o));

  assert_wb_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wb_we_o |-> done_o);

  assert_ret_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ret_load_o |-> (done_o && xfer_load_o));

  assert_busy_ignore_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && !done_o) |=> busy_o);

endmodule

// File: tb/bts_sequencer_bench.sv
module bts_sequencer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 13;
  localparam int WATCHDOG = 20000;

  typedef struct packed {
    logic [31:0] base;
    logic [15:0] list;
    logic [2:0]  mode;
    logic        load;
    logic        wb;
    logic        stall;
    logic        poke;
    logic [31:0] first;
    logic [31:0] fin;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{32'h1000, 16'h0013, 3'b000, 1'b0, 1'b1, 1'b0, 1'b0, 32'h1000, 32'h100C},
    '{32'h1000, 16'h0013, 3'b001, 1'b0, 1'b1, 1'b1, 1'b0, 32'h1004, 32'h100C},
    '{32'h1000, 16'h0013, 3'b010, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0FF8, 32'h0FF4},
    '{32'h1000, 16'h0013, 3'b011, 1'b1, 1'b0, 1'b1, 1'b0, 32'h0FF4, 32'h0FF4},
    '{32'h0400, 16'h003B, 3'b100, 1'b0, 1'b1, 1'b0, 1'b1, 32'h03EC, 32'h03EC},
    '{32'h03EC, 16'h803B, 3'b100, 1'b1, 1'b1, 1'b1, 1'b0, 32'h03EC, 32'h0404},
    '{32'h0200, 16'h8001, 3'b111, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0200, 32'h0208},
    '{32'h0208, 16'h8001, 3'b111, 1'b1, 1'b1, 1'b1, 1'b0, 32'h0200, 32'h0200},
    '{32'h0100, 16'hFFFF, 3'b101, 1'b0, 1'b1, 1'b1, 1'b0, 32'h00C4, 32'h00C0},
    '{32'h0100, 16'h0002, 3'b110, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0100, 32'h00FC},
    '{32'h0050, 16'h0004, 3'b101, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0054, 32'h0054},
    '{32'h0050, 16'h0100, 3'b110, 1'b0, 1'b0, 1'b0, 1'b1, 32'h0054, 32'h0054},
    '{32'h0000, 16'h0001, 3'b011, 1'b0, 1'b1, 1'b0, 1'b0, 32'hFFFFFFFC, 32'hFFFFFFFC}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] base_i = '0;
  logic [15:0] reg_list_i = '0;
  logic [2:0]  mode_i = '0;
  logic        load_i = 1'b0;
  logic        wb_en_i = 1'b0;
  logic        xfer_ready_i = 1'b0;
  logic        busy_o, xfer_valid_o, xfer_load_o, xfer_last_o;
  logic        done_o, wb_we_o, ret_load_o;
  logic [3:0]  xfer_reg_o;
  logic [31:0] xfer_addr_o, wb_base_o;

  int n_tests = 0;
  int n_fail = 0;
  int cycles = 0;

  bts_sequencer u_bts_sequencer (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_i(base_i),
    .reg_list_i(reg_list_i), .mode_i(mode_i), .load_i(load_i), .wb_en_i(wb_en_i),
    .busy_o(busy_o), .xfer_valid_o(xfer_valid_o), .xfer_ready_i(xfer_ready_i),
    .xfer_reg_o(xfer_reg_o), .xfer_addr_o(xfer_addr_o), .xfer_load_o(xfer_load_o),
    .xfer_last_o(xfer_last_o), .done_o(done_o), .wb_we_o(wb_we_o),
    .wb_base_o(wb_base_o), .ret_load_o(ret_load_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WATCHDOG) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog R12 act=%0d exp=<%0d", cycles, WATCHDOG);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests = n_tests + 1;
    if (!ok) begin
      n_fail = n_fail + 1;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic int bits_set(input logic [15:0] m);
    int c = 0;
    for (int i = 0; i < 16; i++) if (m[i]) c++;
    return c;
  endfunction

  function automatic int lowest(input logic [15:0] m);
    for (int i = 0; i < 16; i++) if (m[i]) return i;
    return 0;
  endfunction

  task automatic run_op(input vec_t v, input string mtag);
    logic [15:0] rem = v.list;
    int n = bits_set(v.list);
    int k = 0;
    int tick = 0;
    logic rdy;
    @(negedge clk);
    base_i = v.base; reg_list_i = v.list; mode_i = v.mode;
    load_i = v.load; wb_en_i = v.wb; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    while (k < n) begin
      check(xfer_valid_o === 1'b1, "R12 valid", 32'(xfer_valid_o), 1);
      check(xfer_reg_o == 4'(lowest(rem)), "R2 reg index", 32'(xfer_reg_o), 32'(lowest(rem)));
      check(xfer_addr_o == v.first + 32'(4*k), {mtag, " R3 R4 addr"}, xfer_addr_o, v.first + 32'(4*k));
      check(xfer_last_o == (k == n-1), "R8 last", 32'(xfer_last_o), 32'(k == n-1));
      check(xfer_load_o == v.load, "R2 dir", 32'(xfer_load_o), 32'(v.load));
      rdy = v.stall ? ((tick % 3) != 2) : 1'b1;
      xfer_ready_i = rdy;
      if (v.poke && tick == 0) begin
        start_i = 1'b1; base_i = 32'hDEAD0000; reg_list_i = 16'h0F0F; mode_i = 3'b001;
      end
      @(negedge clk);
      start_i = 1'b0;
      if (rdy) begin
        k++;
        rem[lowest(rem)] = 1'b0;
      end
      tick++;
      if (tick > 200) break;
    end
    xfer_ready_i = 1'b0;
    check(done_o === 1'b1, "R12 done", 32'(done_o), 1);
    check(xfer_valid_o === 1'b0, "R2 no extra access", 32'(xfer_valid_o), 0);
    check(wb_base_o == v.fin, {mtag, " R5 wb value"}, wb_base_o, v.fin);
    check(wb_we_o == v.wb, "R5 wb strobe", 32'(wb_we_o), 32'(v.wb));
    check(ret_load_o == (v.load && v.list[15]), "R10 ret", 32'(ret_load_o), 32'(v.load && v.list[15]));
    if (v.poke) check(busy_o === 1'b1, "R11 poke ignored", 32'(busy_o), 1);
    @(negedge clk);
    check(done_o === 1'b0 && busy_o === 1'b0, "R12 idle after done", {30'd0, done_o, busy_o}, 0);
  endtask

  initial begin
    vec_t e;
    repeat (3) @(negedge clk);
    check(!busy_o && !xfer_valid_o && !done_o && !wb_we_o && !ret_load_o, "R1 in reset",
          {27'd0, busy_o, xfer_valid_o, done_o, wb_we_o, ret_load_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy_o && !xfer_valid_o && !done_o && !wb_we_o && !ret_load_o, "R1 after reset",
          {27'd0, busy_o, xfer_valid_o, done_o, wb_we_o, ret_load_o}, 0);

    for (int i = 0; i < NV; i++)
      run_op(VECS[i], VECS[i].mode[2] ? (VECS[i].load ? "R7" : "R6") : "R3");

    // R9: empty list
    e = '{32'h1234, 16'h0000, 3'b011, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0, 32'h1234};
    run_op(e, "R9");
    // R9: empty list on a stack form with write-back off
    e = '{32'h0ABC, 16'h0000, 3'b100, 1'b0, 1'b0, 1'b0, 1'b1, 32'h0, 32'h0ABC};
    run_op(e, "R9");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule